// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Registers

This block gathers the event pulses raised by the transmit and receive engines of a simple Ethernet MAC. It holds them in byte-wide sticky status registers that a host can read. Each side has a status register and a read/write enable mask. In the status register, a host write clears every bit written as 1. A third source is a DMA-complete pulse, which sets a pending flag of its own.

A summary byte shows, per source, whether an enabled interrupt is waiting. These summary bits are active low: a pending source reads as 0. The block drives an active-high interrupt line whenever any enabled source is pending. The framing, CRC and collision logic that raise the events lie outside this block.

The host bus is a plain strobe interface with no back-pressure:
- A write takes effect on the clock edge where `bus_wr` is high.
- A read captures the addressed register into `bus_rdata` on the edge where `bus_rd` is high.
- `bus_rdata` holds that value until the next read.

Top module: `mac_irq_regs`

## Requirements
- R1: After reset every status bit, mask bit and the DMA flag are 0, `irq` is low, `bus_rdata` is 0x00, and the summary register reads 0x07.
- R2: On the transmit side, a 1 on `tx_evt` bit 7, 5, 4, 3, 2, 1 or 0 sets the same bit of the transmit status register (address 0x00). Bit 7 is packet sent, bit 5 is own frame heard back, bit 4 is medium shorted, bit 3 is underflow, bit 2 is collision, bit 1 is sixteenth collision and bit 0 is parity error. A set bit stays set until cleared.
- R3: Transmit status bit 6 always shows the live level of `carrier`. Writes cannot clear it, `tx_evt[6]` has no effect on it, it never raises `irq`, and transmit mask bit 6 always reads 0.
- R4: The receive status register is at address 0x02. Bits 7 (good frame), 4 (reset frame), 3 (runt), 2 (alignment), 1 (CRC) and 0 (FIFO overflow) are set by `rx_evt` bits of the same position. Bits 6 and 5 always read 0.
- R5: A write to address 0x00 or 0x02 clears every status bit whose `bus_wdata` bit is 1. Bits written as 0 are left unchanged.
- R6: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: The transmit mask (0x01) and receive mask (0x03) are read/write. Only positions that hold a sticky status bit are writable, so the transmit mask reads back `wdata & 0xBF` and the receive mask reads back `wdata & 0x9F`.
- R8: The summary register is at address 0x04. Bit 0 is 0 exactly when (transmit status & transmit mask) is nonzero. Bit 1 is 0 exactly when (receive status & receive mask) is nonzero. Bit 2 is 0 exactly when the DMA flag is set. Bits 7..3 read 0.
- R9: A `dma_done` pulse sets the DMA flag. A write to 0x04 with data bit 2 at 1 clears it, and a pulse in that same cycle wins.
- R10: `irq` is high exactly when an unmasked transmit bit, an unmasked receive bit or the DMA flag is set. It goes low from the clock edge of the write that clears the last such bit, and it rises when a mask write enables an already pending bit.
- R11: `bus_rdata` changes only on an edge where `bus_rd` is high. A read of an unmapped address (0x05 to 0x1F) returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt | input | 8 | Single-cycle transmit event pulses, one per status bit |
| carrier | input | 1 | Live carrier-sense level |
| rx_evt | input | 8 | Single-cycle receive event pulses, one per status bit |
| dma_done | input | 1 | Single-cycle DMA-complete pulse |
| bus_addr | input | 5 | Host register address |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The event-to-status path is tried with several pulse patterns:
- Multi-bit transmit pulses, and a receive pulse on all eight lines. The all-lines pulse separates the valid receive positions from the two inert ones.
- Partial clearing writes, which show whether only the written-1 bits fall.
- A pulse landing on the same bit as a clearing write, which separates set-wins from clear-wins.

The summary byte and `irq` are checked with masks both closed and open. These cases tell a pending-but-masked event from an enabled one. They also show the line rising on a late mask write and falling on the edge of the last clear. The carrier level is toggled and written to, to prove that bit 6 stays live and never interrupts.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int DW = 8;

  localparam int A_TX_STAT = 0;
  localparam int A_TX_MASK = 1;
  localparam int A_RX_STAT = 2;
  localparam int A_RX_MASK = 3;
  localparam int A_SUMMARY = 4;

  localparam logic [DW-1:0] TX_STICKY = 8'hBF;
  localparam logic [DW-1:0] TX_LIVE   = 8'h40;
  localparam logic [DW-1:0] RX_STICKY = 8'h9F;
  localparam logic [DW-1:0] RX_LIVE   = 8'h00;

  localparam int SUM_TX_BIT  = 0;
  localparam int SUM_RX_BIT  = 1;
  localparam int SUM_DMA_BIT = 2;
endpackage

// File: rtl/mac_irq_evt_bank.sv
module mac_irq_evt_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] STICKY = '1,
  parameter logic [W-1:0] LIVE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] live,
  input  logic         st_wr,
  input  logic         msk_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         pend
);
  logic [W-1:0] st_q;
  logic [W-1:0] m_q;
  logic [W-1:0] clr;

  assign clr = st_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      m_q  <= '0;
    end else begin
      st_q <= ((st_q & ~clr) | evt) & STICKY;
      if (msk_wr) m_q <= wdata & STICKY;
    end
  end

  assign status = st_q | (live & LIVE);
  assign mask   = m_q;
  assign pend   = |(st_q & m_q);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> st_q[i]);
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && wdata[i] && !evt[i]) |=> !st_q[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt[i] && !(st_wr && wdata[i])) |=> $stable(st_q[i]));
      assert_mask_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msk_wr |=> (m_q[i] == $past(wdata[i])));
    end
  end
endmodule

// File: rtl/mac_irq_summary.sv
module mac_irq_summary
  import mac_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_pend,
  input  logic          rx_pend,
  input  logic          dma_done,
  input  logic          sum_wr,
  input  logic          dma_clr_bit,
  output logic [DW-1:0] summary,
  output logic          irq
);
  logic dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) dma_q <= 1'b0;
    else        dma_q <= (dma_q & ~(sum_wr & dma_clr_bit)) | dma_done;
  end

  always_comb begin
    summary = '0;
    summary[SUM_TX_BIT]  = ~tx_pend;
    summary[SUM_RX_BIT]  = ~rx_pend;
    summary[SUM_DMA_BIT] = ~dma_q;
  end

  assign irq = tx_pend | rx_pend | dma_q;

  assert_dma_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> dma_q);
  assert_dma_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_wr && dma_clr_bit && !dma_done) |=> !dma_q);
endmodule

// File: rtl/mac_irq_regs.sv
module mac_irq_regs
  import mac_irq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_evt,
  input  logic          carrier,
  input  logic [DW-1:0] rx_evt,
  input  logic          dma_done,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [DW-1:0] tx_status, tx_mask, rx_status, rx_mask, summary;
  logic          tx_pend, rx_pend;
  logic          hit_txs, hit_txm, hit_rxs, hit_rxm, hit_sum, mapped;
  logic [DW-1:0] tx_live;

  assign hit_txs = bus_addr == AW'(A_TX_STAT);
  assign hit_txm = bus_addr == AW'(A_TX_MASK);
  assign hit_rxs = bus_addr == AW'(A_RX_STAT);
  assign hit_rxm = bus_addr == AW'(A_RX_MASK);
  assign hit_sum = bus_addr == AW'(A_SUMMARY);
  assign mapped  = hit_txs | hit_txm | hit_rxs | hit_rxm | hit_sum;

  assign tx_live = {DW{carrier}};

  mac_irq_evt_bank #(.W(DW), .STICKY(TX_STICKY), .LIVE(TX_LIVE)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt), .live(tx_live),
    .st_wr(bus_wr & hit_txs), .msk_wr(bus_wr & hit_txm), .wdata(bus_wdata),
    .status(tx_status), .mask(tx_mask), .pend(tx_pend));

  mac_irq_evt_bank #(.W(DW), .STICKY(RX_STICKY), .LIVE(RX_LIVE)) u_rx (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt), .live('0),
    .st_wr(bus_wr & hit_rxs), .msk_wr(bus_wr & hit_rxm), .wdata(bus_wdata),
    .status(rx_status), .mask(rx_mask), .pend(rx_pend));

  mac_irq_summary u_sum (
    .clk(clk), .rst_n(rst_n), .tx_pend(tx_pend), .rx_pend(rx_pend),
    .dma_done(dma_done), .sum_wr(bus_wr & hit_sum),
    .dma_clr_bit(bus_wdata[SUM_DMA_BIT]), .summary(summary), .irq(irq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (1'b1)
        hit_txs: bus_rdata <= tx_status;
        hit_txm: bus_rdata <= tx_mask;
        hit_rxs: bus_rdata <= rx_status;
        hit_rxm: bus_rdata <= rx_mask;
        hit_sum: bus_rdata <= summary;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));
  assert_tx_pend_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_sum && tx_pend) |=> !bus_rdata[SUM_TX_BIT]);
endmodule

// File: tb/mac_irq_regs_tb.sv
module mac_irq_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_evt = '0, rx_evt = '0, bus_wdata = '0;
  logic       carrier = 1'b0, dma_done = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_chk = 0, n_err = 0, cyc = 0;

  always #4 clk = ~clk;

  mac_irq_regs u_dut (.clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .carrier(carrier),
    .rx_evt(rx_evt), .dma_done(dma_done), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [7:0] exp, string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic txp(logic [7:0] v);
    @(negedge clk); tx_evt = v;
    @(negedge clk); tx_evt = '0;
  endtask

  task automatic rxp(logic [7:0] v);
    @(negedge clk); rx_evt = v;
    @(negedge clk); rx_evt = '0;
  endtask

  // entry: {kind[1:0], addr[4:0], data[7:0], expect[7:0]}; kind 0=write 1=read 2=tx pulse 3=rx pulse
  localparam int NV = 19;
  localparam logic [22:0] VEC [NV] = '{
    {2'd1, 5'h00, 8'h00, 8'h00},  // R1 tx status clear
    {2'd1, 5'h04, 8'h00, 8'h07},  // R1 summary idle
    {2'd2, 5'h00, 8'h81, 8'h00},
    {2'd1, 5'h00, 8'h00, 8'h81},  // R2
    {2'd1, 5'h04, 8'h00, 8'h07},  // R8 masked
    {2'd0, 5'h01, 8'hFF, 8'h00},
    {2'd1, 5'h01, 8'h00, 8'hBF},  // R7
    {2'd1, 5'h04, 8'h00, 8'h06},  // R8 tx pending
    {2'd0, 5'h00, 8'h01, 8'h00},
    {2'd1, 5'h00, 8'h00, 8'h80},  // R5 partial clear
    {2'd3, 5'h00, 8'hFF, 8'h00},
    {2'd1, 5'h02, 8'h00, 8'h9F},  // R4
    {2'd0, 5'h03, 8'hFF, 8'h00},
    {2'd1, 5'h03, 8'h00, 8'h9F},  // R7
    {2'd1, 5'h04, 8'h00, 8'h04},  // R8 both pending
    {2'd0, 5'h02, 8'h9F, 8'h00},
    {2'd0, 5'h00, 8'hFF, 8'h00},
    {2'd1, 5'h04, 8'h00, 8'h07},  // R5 all cleared
    {2'd1, 5'h07, 8'h00, 8'h00}   // R11 unmapped
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic [4:0] a;
      logic [7:0] d, e;
      {k, a, d, e} = VEC[i];
      case (k)
        2'd0: wr(a, d);
        2'd1: rd(a, e, $sformatf("table[%0d] R1/R2/R4/R5/R7/R8/R11", i));
        2'd2: txp(d);
        default: rxp(d);
      endcase
    end

    // R3 carrier is live, not clearable, never interrupts
    carrier = 1;
    rd(5'h00, 8'h40, "R3 live high");
    wr(5'h00, 8'h40);
    rd(5'h00, 8'h40, "R3 write no effect");
    check("R3 no irq", {7'd0, irq}, 8'h00);
    carrier = 0;
    txp(8'h40);
    rd(5'h00, 8'h00, "R3 pulse ignored");

    // R6 set wins over same-cycle clear
    @(negedge clk); bus_wr = 1; bus_addr = 5'h00; bus_wdata = 8'h04; tx_evt = 8'h04;
    @(negedge clk); bus_wr = 0; tx_evt = 0;
    rd(5'h00, 8'h04, "R6 set wins");
    check("R10 irq on enabled", {7'd0, irq}, 8'h01);
    wr(5'h00, 8'h04);
    check("R10 irq drops after clear", {7'd0, irq}, 8'h00);

    // R10 mask gating
    wr(5'h01, 8'h00);
    txp(8'h08);
    check("R10 masked no irq", {7'd0, irq}, 8'h00);
    rd(5'h04, 8'h07, "R8 masked pending");
    wr(5'h01, 8'h08);
    check("R10 irq on mask enable", {7'd0, irq}, 8'h01);
    wr(5'h00, 8'h08);
    check("R10 irq after last clear", {7'd0, irq}, 8'h00);

    // R9 DMA flag
    @(negedge clk); dma_done = 1;
    @(negedge clk); dma_done = 0;
    check("R9 irq on dma", {7'd0, irq}, 8'h01);
    rd(5'h04, 8'h03, "R9 dma pending");
    @(negedge clk); bus_wr = 1; bus_addr = 5'h04; bus_wdata = 8'h04; dma_done = 1;
    @(negedge clk); bus_wr = 0; dma_done = 0;
    rd(5'h04, 8'h03, "R9 pulse wins");
    wr(5'h04, 8'h00);
    rd(5'h04, 8'h03, "R9 bit2 zero keeps");
    wr(5'h04, 8'h04);
    rd(5'h04, 8'h07, "R9 cleared");
    check("R9 irq low", {7'd0, irq}, 8'h00);

    // R11 rdata holds without a read
    rxp(8'h80);
    check("R11 rdata held", bus_rdata, 8'h07);
    check("R10 rx irq", {7'd0, irq}, 8'h01);
    rd(5'h04, 8'h05, "R8 rx pending");
    rxp(8'h60);
    rd(5'h02, 8'h80, "R4 inert bits");
    wr(5'h02, 8'hFF);
    check("R10 rx irq drops", {7'd0, irq}, 8'h00);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule